// File: doc/BRIEF.md
# Tachometer Interrupt Qualification Logic

This block decides whether a fault pulse from a fan tachometer may latch a bit in the interrupt status register. Each tachometer input is tied to one PWM output through a programmable association field. A fault is dropped in any of these cases: the associated PWM's current duty is zero, that fan is switched off, the tachometer's minimum limit is all ones, or the association field holds the reserved code. A fault that passes these tests and whose per-tach enable is set latches a sticky status bit. Reading the status register clears that bit.

Configuration goes through a small register port. A lock input, once seen high, freezes the configuration registers until reset. A temperature interrupt-enable register is held beside the tach configuration under the same lock. Period measurement and PWM generation belong to neighbouring blocks. Their results arrive here as duty values, enables, fault pulses and limits.

Top module: `tach_irq_qual`

## Requirements
- R1: After reset the register at address 0 (association) reads A4h. Address 1 (tach enables) reads 00h. Address 2 (temperature enables) reads 0Eh. Address 3 (status) reads 00h and the status output is 0.
- R2: Association field t sits in bits [2t+1:2t] of address 0. Codes 00, 01 and 10 select PWM 1, 2 and 3. A qualified fault on tach t sets status bit t on the clock edge where the fault is sampled.
- R3: A fault sets no status bit while the duty of its associated PWM is 00h.
- R4: A fault sets no status bit while the enable of its associated fan is low.
- R5: A fault sets no status bit while its tach minimum limit is FFFFh.
- R6: An association field holding code 11 suppresses that tach's faults.
- R7: A fault sets status bit t only while bit t of address 1 is set. Bits above the tach count read 0.
- R8: Status bits are sticky. A read of address 3 returns them and clears them on that edge. A bit with a qualified fault in the same cycle stays set.
- R9: On the edge after lock_req is seen high, writes to addresses 0, 1 and 2 have no effect. The lock holds until reset.
- R10: Only bits [3:0] of address 2 are stored. Bits [7:4] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read of address 3 clears status) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| lock_req | input | 1 | Sets the configuration lock |
| pwm_duty | input | 24 | Current duty per PWM, PWM1 in bits [7:0] |
| fan_en | input | 3 | Fan enable per PWM |
| tach_fault | input | 4 | Fault pulse per tach |
| tach_min | input | 64 | Minimum limit per tach, tach1 in bits [15:0] |
| status | output | 4 | Sticky interrupt status per tach |

## Verification
The bench builds the block with its default parameters: four tachs, three PWMs, 8-bit duties and 16-bit limits. With these values all four association codes, including the reserved one, can be hit for every tach, and the all-ones limit can be driven exactly. Random duty, enable, limit and fault patterns are mixed with clear-on-read cycles, both before and after the lock is taken. This exercises reads that coincide with a new fault, and writes that arrive while the lock is held.

// File: rtl/tach_qual_pkg.sv
// Shared constants and the register address map for the tach qualifier.
// Assumes a 2-bit association field and an 8-bit register port.
package tach_qual_pkg;
    localparam int SEL_W   = 2;
    localparam int TEMP_W  = 4;
    localparam logic [7:0]        ASSOC_RST  = 8'hA4;
    localparam logic [TEMP_W-1:0] TEMPEN_RST = 4'hE;

    typedef enum logic [1:0] {
        REG_ASSOC  = 2'd0,
        REG_TIEN   = 2'd1,
        REG_TEMPEN = 2'd2,
        REG_STATUS = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/tach_cfg_regs.sv
// Configuration registers: tach association, tach enables, temperature
// enables and the lock. Assumes NUM_TACH*SEL_W <= DATA_W.
module tach_cfg_regs
    import tach_qual_pkg::*;
#(
    parameter int NUM_TACH = 4,
    parameter int DATA_W   = 8,
    localparam int ASSOC_W = NUM_TACH * SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                lock_req,
    output logic [ASSOC_W-1:0]  assoc_o,
    output logic [NUM_TACH-1:0] tien_o,
    output logic [TEMP_W-1:0]   tempen_o,
    output logic                lock_o
);
    logic cfg_we;
    assign cfg_we = wr_en && !lock_o;

    // Latch the lock; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        lock_o <= 1'b0;
        else if (lock_req) lock_o <= 1'b1;
    end

    // Configuration writes, blocked while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assoc_o  <= ASSOC_RST[ASSOC_W-1:0];
            tien_o   <= '0;
            tempen_o <= TEMPEN_RST;
        end else if (cfg_we) begin
            case (addr)
                REG_ASSOC:  assoc_o  <= wdata[ASSOC_W-1:0];
                REG_TIEN:   tien_o   <= wdata[NUM_TACH-1:0];
                REG_TEMPEN: tempen_o <= wdata[TEMP_W-1:0];
                default: ;
            endcase
        end
    end

    // R9
    lock_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);
    // R9
    locked_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> ($stable(assoc_o) && $stable(tien_o) && $stable(tempen_o)));
endmodule

// File: rtl/tach_fault_gate.sv
// Per-tach fault qualification: selects the associated PWM and drops the
// fault on zero duty, fan off, all-ones limit, reserved code or tach disable.
// Assumes codes at or above NUM_PWM are unassociated.
module tach_fault_gate
    import tach_qual_pkg::*;
#(
    parameter int NUM_TACH = 4,
    parameter int NUM_PWM  = 3,
    parameter int DUTY_W   = 8,
    parameter int LIMIT_W  = 16
) (
    input  logic [NUM_TACH*SEL_W-1:0]   assoc_i,
    input  logic [NUM_TACH-1:0]         tien_i,
    input  logic [NUM_PWM*DUTY_W-1:0]   pwm_duty,
    input  logic [NUM_PWM-1:0]          fan_en,
    input  logic [NUM_TACH-1:0]         tach_fault,
    input  logic [NUM_TACH*LIMIT_W-1:0] tach_min,
    output logic [NUM_TACH-1:0]         qual_o
);
    for (genvar t = 0; t < NUM_TACH; t++) begin : g_tach
        logic [SEL_W-1:0] sel;
        logic             pwm_live;
        logic             limit_off;
        assign sel       = assoc_i[t*SEL_W +: SEL_W];
        assign limit_off = (tach_min[t*LIMIT_W +: LIMIT_W] == '1);

        // Running state of the associated PWM; reserved codes match nothing.
        always_comb begin
            pwm_live = 1'b0;
            for (int p = 0; p < NUM_PWM; p++) begin
                if (sel == SEL_W'(p))
                    pwm_live = (pwm_duty[p*DUTY_W +: DUTY_W] != '0) && fan_en[p];
            end
        end

        assign qual_o[t] = tach_fault[t] && tien_i[t] && pwm_live && !limit_off;
    end
endmodule

// File: rtl/tach_status_bank.sv
// Sticky status bits with clear-on-read; a same-cycle fault wins over clear.
module tach_status_bank #(
    parameter int NUM_TACH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TACH-1:0] qual_i,
    input  logic                clr_i,
    output logic [NUM_TACH-1:0] status_o
);
    // Hold, clear on read, then merge new qualified faults.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (clr_i ? '0 : status_o) | qual_i;
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));
    // R2
    set_needs_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_i == '0) |=> ((status_o & ~$past(status_o)) == '0));
endmodule

// File: rtl/tach_irq_qual.sv
// Top of the tach interrupt qualifier: register port, configuration,
// fault gating and sticky status. Read data is combinational on addr.
module tach_irq_qual
    import tach_qual_pkg::*;
#(
    parameter int NUM_TACH = 4,
    parameter int NUM_PWM  = 3,
    parameter int DUTY_W   = 8,
    parameter int LIMIT_W  = 16,
    parameter int DATA_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [1:0]                  addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    input  logic                        lock_req,
    input  logic [NUM_PWM*DUTY_W-1:0]   pwm_duty,
    input  logic [NUM_PWM-1:0]          fan_en,
    input  logic [NUM_TACH-1:0]         tach_fault,
    input  logic [NUM_TACH*LIMIT_W-1:0] tach_min,
    output logic [NUM_TACH-1:0]         status
);
    localparam int ASSOC_W = NUM_TACH * SEL_W;

    logic [ASSOC_W-1:0]  assoc;
    logic [NUM_TACH-1:0] tien;
    logic [TEMP_W-1:0]   tempen;
    logic                locked;
    logic [NUM_TACH-1:0] qual;
    logic                rd_status;

    assign rd_status = rd_en && (addr == REG_STATUS);

    tach_cfg_regs #(.NUM_TACH(NUM_TACH), .DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .lock_req(lock_req), .assoc_o(assoc), .tien_o(tien),
        .tempen_o(tempen), .lock_o(locked)
    );

    tach_fault_gate #(.NUM_TACH(NUM_TACH), .NUM_PWM(NUM_PWM),
                      .DUTY_W(DUTY_W), .LIMIT_W(LIMIT_W)) u_gate (
        .assoc_i(assoc), .tien_i(tien), .pwm_duty(pwm_duty), .fan_en(fan_en),
        .tach_fault(tach_fault), .tach_min(tach_min), .qual_o(qual)
    );

    tach_status_bank #(.NUM_TACH(NUM_TACH)) u_stat (
        .clk(clk), .rst_n(rst_n), .qual_i(qual), .clr_i(rd_status),
        .status_o(status)
    );

    // Read mux; unused upper bits read zero.
    always_comb begin
        case (addr)
            REG_ASSOC:  rdata = DATA_W'(assoc);
            REG_TIEN:   rdata = DATA_W'(tien);
            REG_TEMPEN: rdata = DATA_W'(tempen);
            default:    rdata = DATA_W'(status);
        endcase
    end

    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && qual == '0) |=> (status == '0));
    // R9
    lock_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_en && addr == REG_ASSOC) |=> $stable(rdata) || addr != REG_ASSOC);
endmodule

// File: tb/tach_irq_qual_test.sv
module tach_irq_qual_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       wr_en = 0, rd_en = 0, lock_req = 0;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic [7:0] duty [3];
    logic [2:0] fen = 0;
    logic [3:0] fault = 0;
    logic [15:0] tmin [4];
    logic [3:0] status;

    tach_irq_qual uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .lock_req(lock_req),
        .pwm_duty({duty[2], duty[1], duty[0]}), .fan_en(fen),
        .tach_fault(fault), .tach_min({tmin[3], tmin[2], tmin[1], tmin[0]}),
        .status(status)
    );

    int total = 0, bad = 0;
    bit done = 0;
    logic [7:0] m_assoc, m_ien, m_temp;
    logic [3:0] m_status;
    bit m_lock;

    function automatic logic [7:0] model_read(logic [1:0] a);
        case (a)
            2'd0: return m_assoc;
            2'd1: return m_ien;
            2'd2: return m_temp;
            default: return {4'b0, m_status};
        endcase
    endfunction

    function automatic logic [3:0] model_qual();
        logic [3:0] q = 0;
        for (int t = 0; t < 4; t++) begin
            logic [1:0] s = m_assoc[2*t +: 2];
            if (s != 2'd3)
                q[t] = fault[t] && m_ien[t] && duty[s] != 0 && fen[s] && tmin[t] != 16'hFFFF;
        end
        return q;
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        m_assoc = 8'hA4; m_ien = 0; m_temp = 8'h0E; m_status = 0; m_lock = 0;
    endtask

    // One clock: check read data, step the model, check status.
    task automatic tick(string req);
        logic [3:0] q;
        #1 check({req, " rdata"}, rdata, model_read(addr));
        q = model_qual();
        @(posedge clk);
        if (wr_en && !m_lock) begin
            case (addr)
                2'd0: m_assoc = wdata;
                2'd1: m_ien = {4'b0, wdata[3:0]};
                2'd2: m_temp = {4'b0, wdata[3:0]};
                default: ;
            endcase
        end
        m_status = ((rd_en && addr == 2'd3) ? 4'b0 : m_status) | q;
        if (lock_req) m_lock = 1;
        @(negedge clk);
        check({req, " status"}, {4'b0, status}, {4'b0, m_status});
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; lock_req = 0; fault = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d, string req);
        idle(); wr_en = 1; addr = a; wdata = d; tick(req); idle();
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] exp, string req);
        idle(); rd_en = 1; addr = a;
        #1 check({req, " literal"}, rdata, exp);
        tick(req); idle();
    endtask

    task automatic rand_cycle(string req);
        for (int p = 0; p < 3; p++) duty[p] = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom);
        fen = 3'($urandom) | 3'($urandom);
        for (int t = 0; t < 4; t++) tmin[t] = ($urandom % 5 == 0) ? 16'hFFFF : 16'($urandom);
        fault = 4'($urandom);
        addr = 2'($urandom);
        rd_en = ($urandom % 4 == 0);
        wr_en = ($urandom % 6 == 0);
        wdata = (addr == 2'd1) ? (8'($urandom) | 8'h0C) : 8'($urandom);
        lock_req = 0;
        tick(req);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < 3; p++) duty[p] = 8'h40;
        for (int t = 0; t < 4; t++) tmin[t] = 16'h0100;
        fen = 3'b111;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        rd(2'd0, 8'hA4, "R1");
        rd(2'd1, 8'h00, "R1");
        rd(2'd2, 8'h0E, "R1");
        rd(2'd3, 8'h00, "R1");

        // R10 upper bits of temperature enables not stored
        wr(2'd2, 8'hFF, "R10");
        rd(2'd2, 8'h0F, "R10");

        // R7 disabled tach does not latch
        fault = 4'hF; tick("R7"); idle();
        check("R7 status", {4'b0, status}, 8'h00);
        wr(2'd1, 8'hFF, "R7");
        rd(2'd1, 8'h0F, "R7");

        // R2 default association: tach2 -> PWM2
        fault = 4'b0010; tick("R2"); idle();
        check("R2 status", {4'b0, status}, 8'h02);
        rd(2'd3, 8'h02, "R8");
        check("R8 cleared", {4'b0, status}, 8'h00);

        // R3 PWM3 duty zero blocks tach3 and tach4
        duty[2] = 0; fault = 4'b1100; tick("R3"); idle(); duty[2] = 8'h40;
        check("R3 status", {4'b0, status}, 8'h00);

        // R4 fan off blocks tach1
        fen = 3'b110; fault = 4'b0001; tick("R4"); idle(); fen = 3'b111;
        check("R4 status", {4'b0, status}, 8'h00);

        // R5 all-ones limit blocks tach4 only
        tmin[3] = 16'hFFFF; fault = 4'b1001; tick("R5"); idle(); tmin[3] = 16'h0100;
        check("R5 status", {4'b0, status}, 8'h01);

        // R8 read with a same-cycle fault keeps the bit
        rd_en = 1; addr = 2'd3; fault = 4'b0001; tick("R8"); idle();
        check("R8 kept", {4'b0, status}, 8'h01);
        rd(2'd3, 8'h01, "R8");

        // R6 reserved code on tach1, tach2 moved to PWM1
        wr(2'd0, 8'hA3, "R6");
        fault = 4'b0011; tick("R6"); idle();
        check("R6 status", {4'b0, status}, 8'h02);
        rd(2'd3, 8'h02, "R8");

        // Random phase, unlocked
        for (int i = 0; i < 600; i++) rand_cycle("R2/R3/R4/R5/R6/R7/R8");

        // R9 lock then attempt writes
        idle(); lock_req = 1; tick("R9"); idle();
        wr(2'd0, 8'h00, "R9");
        wr(2'd1, 8'h00, "R9");
        wr(2'd2, 8'h00, "R9");
        for (int i = 0; i < 600; i++) rand_cycle("R9");
        idle(); addr = 2'd0; #1 check("R9 assoc held", rdata, m_assoc);
        check("R9 lock held", {7'b0, uut.u_cfg.lock_o}, 8'h01);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule